// File: doc/BRIEF.md
# Inter-processor event hub

Each processor in a multi-processor system owns one of these hubs. Software or a local event-routing fabric fires one of eight send triggers. Each trigger has its own channel mask, and the hub drives a one-cycle pulse on every shared inter-processor channel selected by that mask. When several triggers fire in the same cycle, their masks are ORed together. In the other direction, the hub watches the incoming shared channels. Each of its eight receive flags has its own listen mask and latches whenever any channel in that mask pulses.

Every receive flag can raise the interrupt line through an enable register. Writing the enable register writes all enables at once, and two further offsets set or clear individual enables. Each send trigger can be subscribed to one of sixteen fabric lines, so a pulse on that line fires the trigger without the processor. Each receive flag can be published onto a fabric line in the same way. Four scratch words give processors a place to store small values. A channel is a single wire, so pulses from several sources that land in the same cycle are seen as one event. Software protocols must leave room between events on one channel, for example by acknowledging on a second channel.

Top module: `ipc_event_hub`

## Requirements
- R1: After reset every register reads 0 and `chan_out`, `fab_out` and `irq` are low.
- R2: A bus write with `bus_wdata[0]`=1 to trigger offset 0x000+4n drives `chan_out` equal to the channel mask of trigger n (offset 0x510+4n, bit i = channel i) for exactly the one cycle after the write. A write with `bus_wdata[0]`=0 has no effect.
- R3: When several triggers fire in one cycle, by software and/or fabric, `chan_out` is the OR of their masks.
- R4: Subscribe register 0x080+4n: bit 31 enables, bits [3:0] pick a fabric line. While enabled, a pulse on `fab_in` at that line fires trigger n exactly as a software write does. While disabled, the pulse has no effect.
- R5: Receive flag n (read/write at 0x100+4n, bit 0, 1 = generated) sets at the clock edge where `chan_in` ANDed with listen mask n (offset 0x590+4n, bit i = channel i) is nonzero. Writing 0 clears it. A set wins over a clear written in the same cycle. Pulses from several channels in one cycle give a single set flag.
- R6: Publish register 0x180+4n: bit 31 enables, bits [3:0] pick a fabric line. When flag n's listen mask matches `chan_in`, `fab_out` at that line pulses for the one following cycle.
- R7: Offset 0x300 reads and writes the enable vector. Ones written to 0x304 set enables, and ones written to 0x308 clear them. All three offsets read the enable vector.
- R8: Offset 0x30C reads flag AND enable and ignores writes. `irq` is high exactly while that value is nonzero.
- R9: The four scratch words at 0x610..0x61C are plain 32-bit read/write storage.
- R10: Reads of unmapped or unaligned offsets, and of trigger offsets, return 0, and writes there change nothing. Mask registers read back bits [7:0] only. Subscribe and publish registers read back bits 31 and [3:0] only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, 0 when not reading |
| chan_in | input | 8 | Shared channel pulses from other hubs |
| chan_out | output | 8 | Shared channel pulses driven by this hub |
| fab_in | input | 16 | Local fabric lines that can fire triggers |
| fab_out | output | 16 | Local fabric lines pulsed by receive flags |
| irq | output | 1 | Interrupt, OR of pending flags |

## Verification
The hardest situation to reach is a receive flag being set and cleared by software in the same cycle. In the same class are one cycle that fires a software trigger and a subscribed fabric trigger together, and a fabric pulse on a line whose subscription is disabled. The directed part of the stimulus lines these collisions up on purpose: a write of 0 to a flag goes in the same cycle as a matching channel pulse, and a trigger write goes together with a fabric pulse. A random phase then mixes writes, reads and channel and fabric traffic over the whole map, while a behavioural model predicts every output each cycle.

// File: rtl/ipc_hub_pkg.sv
// Package: word offsets of the hub's register map and the bus width.
// Assumes 32-bit byte-addressed accesses; offsets are word indices (byte/4).
package ipc_hub_pkg;
    localparam int BUS_W    = 32;
    localparam int W_TRIG   = 'h000 / 4;
    localparam int W_SUB    = 'h080 / 4;
    localparam int W_FLAG   = 'h100 / 4;
    localparam int W_PUB    = 'h180 / 4;
    localparam int W_IEN    = 'h300 / 4;
    localparam int W_ISET   = 'h304 / 4;
    localparam int W_ICLR   = 'h308 / 4;
    localparam int W_PEND   = 'h30C / 4;
    localparam int W_SMASK  = 'h510 / 4;
    localparam int W_RMASK  = 'h590 / 4;
    localparam int W_SCR    = 'h610 / 4;
    localparam int LINK_BIT = 31;
endpackage

// File: rtl/ipc_hub_regs.sv
// Register file and bus decode of the event hub.
// Holds masks, subscribe/publish links, interrupt enables and scratch words.
// Emits one-cycle software trigger strobes and flag write strobes; the flags
// themselves live in the receive unit and come back in for reads.
// Assumes N_TRIG, N_FLAG <= 32 and N_CHAN <= 32 so the fixed map does not overlap.
module ipc_hub_regs
    import ipc_hub_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int N_FLAG = 8,
    parameter int N_CHAN = 8,
    parameter int LINK_W = 4,
    parameter int N_SCR  = 4,
    parameter int AW     = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_sel,
    input  logic                               bus_we,
    input  logic [AW-1:0]                      bus_addr,
    input  logic [BUS_W-1:0]                   bus_wdata,
    output logic [BUS_W-1:0]                   bus_rdata,
    input  logic [N_FLAG-1:0]                  flags,
    output logic [N_TRIG-1:0]                  sw_trig,
    output logic [N_TRIG-1:0][N_CHAN-1:0]      send_mask,
    output logic [N_FLAG-1:0][N_CHAN-1:0]      recv_mask,
    output logic [N_TRIG-1:0]                  sub_en,
    output logic [N_TRIG-1:0][LINK_W-1:0]      sub_idx,
    output logic [N_FLAG-1:0]                  pub_en,
    output logic [N_FLAG-1:0][LINK_W-1:0]      pub_idx,
    output logic [N_FLAG-1:0]                  inten,
    output logic [N_FLAG-1:0]                  flag_wr,
    output logic                               flag_wr_val
);
    localparam int WORD_W = AW - 2;
    localparam int PAD_W  = BUS_W - 1 - LINK_W;

    logic [N_SCR-1:0][BUS_W-1:0] scratch;
    logic                        aligned;
    logic                        wr;
    logic                        rd;
    int                          word;

    // Decode the access kind and the word index.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        wr      = bus_sel && bus_we && aligned;
        rd      = bus_sel && !bus_we && aligned;
        word    = int'(bus_addr[AW-1:2]);
    end

    // Software trigger strobes and flag write strobes, one per write.
    always_comb begin
        for (int n = 0; n < N_TRIG; n++)
            sw_trig[n] = wr && (word == W_TRIG + n) && bus_wdata[0];
        for (int n = 0; n < N_FLAG; n++)
            flag_wr[n] = wr && (word == W_FLAG + n);
        flag_wr_val = bus_wdata[0];
    end

    // Per-trigger configuration: channel mask and fabric subscription.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_mask <= '0;
            sub_en    <= '0;
            sub_idx   <= '0;
        end else if (wr) begin
            for (int n = 0; n < N_TRIG; n++) begin
                if (word == W_SMASK + n) send_mask[n] <= bus_wdata[N_CHAN-1:0];
                if (word == W_SUB + n) begin
                    sub_en[n]  <= bus_wdata[LINK_BIT];
                    sub_idx[n] <= bus_wdata[LINK_W-1:0];
                end
            end
        end
    end

    // Per-flag configuration: listen mask and fabric publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recv_mask <= '0;
            pub_en    <= '0;
            pub_idx   <= '0;
        end else if (wr) begin
            for (int n = 0; n < N_FLAG; n++) begin
                if (word == W_RMASK + n) recv_mask[n] <= bus_wdata[N_CHAN-1:0];
                if (word == W_PUB + n) begin
                    pub_en[n]  <= bus_wdata[LINK_BIT];
                    pub_idx[n] <= bus_wdata[LINK_W-1:0];
                end
            end
        end
    end

    // Interrupt enables: full write, set-by-ones, clear-by-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inten <= '0;
        else if (wr && word == W_IEN)
            inten <= bus_wdata[N_FLAG-1:0];
        else if (wr && word == W_ISET)
            inten <= inten | bus_wdata[N_FLAG-1:0];
        else if (wr && word == W_ICLR)
            inten <= inten & ~bus_wdata[N_FLAG-1:0];
    end

    // Scratch storage words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch <= '0;
        else if (wr)
            for (int n = 0; n < N_SCR; n++)
                if (word == W_SCR + n) scratch[n] <= bus_wdata;
    end

    // Read multiplexer; anything not matched reads 0.
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            for (int n = 0; n < N_TRIG; n++) begin
                if (word == W_SMASK + n) bus_rdata = BUS_W'(send_mask[n]);
                if (word == W_SUB + n)
                    bus_rdata = {sub_en[n], {PAD_W{1'b0}}, sub_idx[n]};
            end
            for (int n = 0; n < N_FLAG; n++) begin
                if (word == W_RMASK + n) bus_rdata = BUS_W'(recv_mask[n]);
                if (word == W_PUB + n)
                    bus_rdata = {pub_en[n], {PAD_W{1'b0}}, pub_idx[n]};
                if (word == W_FLAG + n) bus_rdata = BUS_W'(flags[n]);
            end
            if (word == W_IEN || word == W_ISET || word == W_ICLR)
                bus_rdata = BUS_W'(inten);
            if (word == W_PEND)
                bus_rdata = BUS_W'(flags & inten);
            for (int n = 0; n < N_SCR; n++)
                if (word == W_SCR + n) bus_rdata = scratch[n];
        end
    end

    logic unused_word_w;
    assign unused_word_w = (WORD_W > 0);
endmodule

// File: rtl/ipc_hub_send.sv
// Send unit: merges software and fabric triggers and drives the shared channels.
// Each fired trigger ORs its channel mask into a registered one-cycle pulse.
// Assumes fab_in lines are single-cycle pulses in the hub's clock domain.
module ipc_hub_send #(
    parameter int N_TRIG = 8,
    parameter int N_CHAN = 8,
    parameter int LINK_W = 4,
    parameter int N_FAB  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_TRIG-1:0]             sw_trig,
    input  logic [N_TRIG-1:0]             sub_en,
    input  logic [N_TRIG-1:0][LINK_W-1:0] sub_idx,
    input  logic [N_FAB-1:0]              fab_in,
    input  logic [N_TRIG-1:0][N_CHAN-1:0] send_mask,
    output logic [N_CHAN-1:0]             chan_out
);
    logic [N_TRIG-1:0] fired;
    logic [N_CHAN-1:0] chan_nxt;

    // One trigger source per task: software strobe or subscribed fabric line.
    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        assign fired[g] = sw_trig[g] || (sub_en[g] && fab_in[sub_idx[g]]);
    end

    // OR the masks of every trigger fired in this cycle.
    always_comb begin
        chan_nxt = '0;
        for (int n = 0; n < N_TRIG; n++)
            if (fired[n]) chan_nxt = chan_nxt | send_mask[n];
    end

    // Register the channel pulse; it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) chan_out <= '0;
        else        chan_out <= chan_nxt;
    end
endmodule

// File: rtl/ipc_hub_recv.sv
// Receive unit: latches flags from matching channel pulses, publishes them onto
// fabric lines and forms the interrupt.
// Assumes chan_in is already synchronous to clk.
module ipc_hub_recv #(
    parameter int N_FLAG = 8,
    parameter int N_CHAN = 8,
    parameter int LINK_W = 4,
    parameter int N_FAB  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_CHAN-1:0]             chan_in,
    input  logic [N_FLAG-1:0][N_CHAN-1:0] recv_mask,
    input  logic [N_FLAG-1:0]             pub_en,
    input  logic [N_FLAG-1:0][LINK_W-1:0] pub_idx,
    input  logic [N_FLAG-1:0]             inten,
    input  logic [N_FLAG-1:0]             flag_wr,
    input  logic                          flag_wr_val,
    output logic [N_FLAG-1:0]             flags,
    output logic [N_FAB-1:0]              fab_out,
    output logic                          irq
);
    logic [N_FLAG-1:0] hit;
    logic [N_FAB-1:0]  fab_nxt;

    // A flag is hit when any channel in its listen mask pulses.
    for (genvar g = 0; g < N_FLAG; g++) begin : g_hit
        assign hit[g] = |(chan_in & recv_mask[g]);
    end

    // Fabric lines to pulse for this cycle's hits.
    always_comb begin
        fab_nxt = '0;
        for (int n = 0; n < N_FLAG; n++)
            if (hit[n] && pub_en[n]) fab_nxt[pub_idx[n]] = 1'b1;
    end

    // Flag state: hardware set has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int n = 0; n < N_FLAG; n++) begin
                if (hit[n])          flags[n] <= 1'b1;
                else if (flag_wr[n]) flags[n] <= flag_wr_val;
            end
        end
    end

    // Registered one-cycle fabric publication.
    always_ff @(posedge clk) begin
        if (!rst_n) fab_out <= '0;
        else        fab_out <= fab_nxt;
    end

    // Interrupt is the OR of enabled flags.
    assign irq = |(flags & inten);
endmodule

// File: rtl/ipc_event_hub.sv
// Top of the inter-processor event hub: register file, send unit, receive unit.
// Assumes a single clock domain and 32-bit aligned register accesses.
module ipc_event_hub
    import ipc_hub_pkg::*;
#(
    parameter int N_TRIG = 8,
    parameter int N_FLAG = 8,
    parameter int N_CHAN = 8,
    parameter int LINK_W = 4,
    parameter int N_SCR  = 4,
    parameter int AW     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [N_CHAN-1:0]     chan_in,
    output logic [N_CHAN-1:0]     chan_out,
    input  logic [(1<<LINK_W)-1:0] fab_in,
    output logic [(1<<LINK_W)-1:0] fab_out,
    output logic                  irq
);
    localparam int N_FAB = 1 << LINK_W;

    logic [N_TRIG-1:0]             sw_trig;
    logic [N_TRIG-1:0][N_CHAN-1:0] send_mask;
    logic [N_FLAG-1:0][N_CHAN-1:0] recv_mask;
    logic [N_TRIG-1:0]             sub_en;
    logic [N_TRIG-1:0][LINK_W-1:0] sub_idx;
    logic [N_FLAG-1:0]             pub_en;
    logic [N_FLAG-1:0][LINK_W-1:0] pub_idx;
    logic [N_FLAG-1:0]             inten;
    logic [N_FLAG-1:0]             flag_wr;
    logic                          flag_wr_val;
    logic [N_FLAG-1:0]             flags;

    ipc_hub_regs #(
        .N_TRIG(N_TRIG), .N_FLAG(N_FLAG), .N_CHAN(N_CHAN),
        .LINK_W(LINK_W), .N_SCR(N_SCR), .AW(AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flags(flags), .sw_trig(sw_trig),
        .send_mask(send_mask), .recv_mask(recv_mask),
        .sub_en(sub_en), .sub_idx(sub_idx),
        .pub_en(pub_en), .pub_idx(pub_idx),
        .inten(inten), .flag_wr(flag_wr), .flag_wr_val(flag_wr_val)
    );

    ipc_hub_send #(
        .N_TRIG(N_TRIG), .N_CHAN(N_CHAN), .LINK_W(LINK_W), .N_FAB(N_FAB)
    ) u_send (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig),
        .sub_en(sub_en), .sub_idx(sub_idx), .fab_in(fab_in),
        .send_mask(send_mask), .chan_out(chan_out)
    );

    ipc_hub_recv #(
        .N_FLAG(N_FLAG), .N_CHAN(N_CHAN), .LINK_W(LINK_W), .N_FAB(N_FAB)
    ) u_recv (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in),
        .recv_mask(recv_mask), .pub_en(pub_en), .pub_idx(pub_idx),
        .inten(inten), .flag_wr(flag_wr), .flag_wr_val(flag_wr_val),
        .flags(flags), .fab_out(fab_out), .irq(irq)
    );
endmodule

// File: rtl/ipc_hub_chk.sv
// Checker for the event hub, bound to the top; watches ports and unit boundaries.
module ipc_hub_chk #(
    parameter int N_FLAG = 8,
    parameter int N_CHAN = 8,
    parameter int N_FAB  = 16,
    parameter int AW     = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_sel,
    input logic                          bus_we,
    input logic [AW-1:0]                 bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic [N_CHAN-1:0]             chan_in,
    input logic [N_CHAN-1:0]             chan_out,
    input logic [N_FAB-1:0]              fab_in,
    input logic [N_FAB-1:0]              fab_out,
    input logic [N_FLAG-1:0][N_CHAN-1:0] recv_mask,
    input logic [N_FLAG-1:0]             flags,
    input logic [N_FLAG-1:0]             inten
);
    logic trig_wr;
    logic iset_wr;
    logic pend_rd;

    always_comb begin
        trig_wr = bus_sel && bus_we && (bus_addr < AW'(32)) && bus_wdata[0];
        iset_wr = bus_sel && bus_we && (bus_addr == AW'('h304));
        pend_rd = bus_sel && !bus_we && (bus_addr == AW'('h30C));
    end

    // R2
    chan_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_out != '0) |-> $past(trig_wr || (fab_in != '0)));

    // R6
    fab_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_out != '0) |-> $past(chan_in != '0));

    // R8
    pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_rd |-> (bus_rdata == 32'(flags & inten)));

    // R7
    inten_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iset_wr |=> ((inten & $past(bus_wdata[N_FLAG-1:0])) == $past(bus_wdata[N_FLAG-1:0])));

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
        // R5
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((chan_in & recv_mask[g]) != '0) |=> flags[g]);
    end
endmodule

bind ipc_event_hub ipc_hub_chk #(
    .N_FLAG(N_FLAG), .N_CHAN(N_CHAN), .N_FAB(N_FAB), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_in(chan_in), .chan_out(chan_out), .fab_in(fab_in), .fab_out(fab_out),
    .recv_mask(recv_mask), .flags(flags), .inten(inten)
);

// File: tb/test_ipc_event_hub.sv
// Bench: behavioural model of the hub, compared against the design every clock.
module test_ipc_event_hub;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  chan_in, chan_out;
    logic [15:0] fab_in, fab_out;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    // Model state.
    int unsigned m_smask[8], m_rmask[8], m_sub[8], m_pub[8], m_scr[4];
    bit [7:0]    m_flags, m_ien, m_chan;
    bit [15:0]   m_fab;

    ipc_event_hub i_ipc_event_hub (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_in(chan_in), .chan_out(chan_out), .fab_in(fab_in),
        .fab_out(fab_out), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            nerr++;
            $display("FAIL watchdog: run hung act=%0d exp<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned m_read(input logic sel, input logic we,
                                           input logic [11:0] a);
        int w;
        if (!(sel && !we) || a[1:0] != 2'b00) return 0;
        w = int'(a >> 2);
        if (w >= 32 && w < 40)   return m_sub[w-32];
        if (w >= 64 && w < 72)   return 32'(m_flags[w-64]);
        if (w >= 96 && w < 104)  return m_pub[w-96];
        if (w >= 192 && w < 195) return 32'(m_ien);
        if (w == 195)            return 32'(m_flags & m_ien);
        if (w >= 324 && w < 332) return m_smask[w-324];
        if (w >= 356 && w < 364) return m_rmask[w-356];
        if (w >= 388 && w < 392) return m_scr[w-388];
        return 0;
    endfunction

    task automatic m_step(input logic sel, input logic we, input logic [11:0] a,
                          input logic [31:0] d, input logic [7:0] ci,
                          input logic [15:0] fi);
        bit wr;
        int w;
        bit [7:0] nchan = '0;
        bit [15:0] nfab = '0;
        bit [7:0] hit = '0;
        wr = sel && we && a[1:0] == 2'b00;
        w  = int'(a >> 2);
        for (int n = 0; n < 8; n++) begin
            bit t;
            t = (wr && w == n && d[0]) ||
                (m_sub[n][31] && fi[m_sub[n] & 15]);
            if (t) nchan |= m_smask[n][7:0];
            hit[n] = (ci & m_rmask[n][7:0]) != 0;
            if (hit[n] && m_pub[n][31]) nfab[m_pub[n] & 15] = 1'b1;
        end
        for (int n = 0; n < 8; n++) begin
            if (hit[n]) m_flags[n] = 1'b1;
            else if (wr && w == 64 + n) m_flags[n] = d[0];
        end
        if (wr) begin
            if (w >= 32 && w < 40)   m_sub[w-32]   = d & 32'h8000000F;
            if (w >= 96 && w < 104)  m_pub[w-96]   = d & 32'h8000000F;
            if (w == 192)            m_ien = d[7:0];
            if (w == 193)            m_ien |= d[7:0];
            if (w == 194)            m_ien &= ~d[7:0];
            if (w >= 324 && w < 332) m_smask[w-324] = d & 32'hFF;
            if (w >= 356 && w < 364) m_rmask[w-356] = d & 32'hFF;
            if (w >= 388 && w < 392) m_scr[w-388] = d;
        end
        m_chan = nchan;
        m_fab  = nfab;
    endtask

    // One clock: drive, check combinational outputs, step model, check registered outputs.
    task automatic cyc(input string tag, input logic sel, input logic we,
                       input logic [11:0] a, input logic [31:0] d,
                       input logic [7:0] ci, input logic [15:0] fi);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
        chan_in = ci; fab_in = fi;
        #1;
        check(tag, "rdata", bus_rdata, m_read(sel, we, a));
        check(tag, "irq", 32'(irq), 32'((m_flags & m_ien) != 0));
        @(posedge clk);
        m_step(sel, we, a, d, ci, fi);
        @(negedge clk);
        check(tag, "chan_out", 32'(chan_out), 32'(m_chan));
        check(tag, "fab_out", 32'(fab_out), 32'(m_fab));
        bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        chan_in = '0; fab_in = '0;
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
        cyc(tag, 1, 1, a, d, '0, '0);
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        cyc(tag, 1, 0, a, 0, '0, '0);
        check(tag, "direct", m_read(1, 0, a), exp);
    endtask

    initial begin
        rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        chan_in = '0; fab_in = '0;
        for (int n = 0; n < 8; n++) begin
            m_smask[n] = 0; m_rmask[n] = 0; m_sub[n] = 0; m_pub[n] = 0;
        end
        for (int n = 0; n < 4; n++) m_scr[n] = 0;
        m_flags = 0; m_ien = 0; m_chan = 0; m_fab = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        rd("R1", 12'h510, 0);
        rd("R1", 12'h300, 0);
        rd("R1", 12'h610, 0);
        cyc("R1", 0, 0, 0, 0, 0, 0);

        // R2: software trigger drives the mask for one cycle
        wr("R2", 12'h510, 32'h0000_0005);
        wr("R2", 12'h51C, 32'hFFFF_FFA0);
        wr("R2", 12'h000, 1);
        cyc("R2", 0, 0, 0, 0, 0, 0);
        wr("R2", 12'h000, 0);
        // R3: software triggers 0 and 3 back to back, then together with fabric
        wr("R3", 12'h00C, 1);
        wr("R4", 12'h08C, 32'h8000_0009);
        cyc("R3", 1, 1, 12'h000, 1, 0, 16'h0200);
        // R4: fabric subscription, enabled and disabled
        cyc("R4", 0, 0, 0, 0, 0, 16'h0200);
        wr("R4", 12'h084, 32'h0000_0002);
        wr("R4", 12'h514, 32'h0000_0002);
        cyc("R4", 0, 0, 0, 0, 0, 16'h0004);

        // R5: receive flag set, unmatched channel, clear, set-wins-over-clear
        wr("R5", 12'h598, 32'h0000_000C);
        cyc("R5", 0, 0, 0, 0, 8'h04, 0);
        rd("R5", 12'h108, 1);
        wr("R5", 12'h108, 0);
        cyc("R5", 0, 0, 0, 0, 8'h01, 0);
        rd("R5", 12'h108, 0);
        cyc("R5", 1, 1, 12'h108, 0, 8'h0C, 0);
        rd("R5", 12'h108, 1);

        // R6: publish flag 2 onto fabric line 13
        wr("R6", 12'h188, 32'h8000_000D);
        cyc("R6", 0, 0, 0, 0, 8'h08, 0);
        rd("R6", 12'h188, 32'h8000_000D);

        // R7, R8: enable register forms and pending/irq
        wr("R7", 12'h300, 32'h0000_0011);
        rd("R7", 12'h304, 32'h11);
        wr("R7", 12'h304, 32'h0000_0004);
        rd("R8", 12'h30C, 32'h04);
        wr("R8", 12'h30C, 32'h0);
        rd("R8", 12'h30C, 32'h04);
        wr("R7", 12'h308, 32'h0000_0004);
        rd("R7", 12'h308, 32'h11);
        wr("R8", 12'h304, 32'h0000_0004);
        wr("R8", 12'h108, 0);
        rd("R8", 12'h30C, 0);

        // R9: scratch words
        wr("R9", 12'h610, 32'hDEAD_BEEF);
        wr("R9", 12'h61C, 32'h1234_5678);
        rd("R9", 12'h610, 32'hDEAD_BEEF);
        rd("R9", 12'h61C, 32'h1234_5678);

        // R10: unmapped, unaligned and partial readback
        wr("R10", 12'h400, 32'hFFFF_FFFF);
        rd("R10", 12'h400, 0);
        wr("R10", 12'h612, 32'h0);
        rd("R10", 12'h610, 32'hDEAD_BEEF);
        rd("R10", 12'h000, 0);
        rd("R10", 12'h51C, 32'hA0);

        // Random mix over the whole map (R2..R10)
        for (int k = 0; k < 600; k++) begin
            logic [11:0] a;
            int sel_r;
            sel_r = $urandom_range(0, 9);
            case (sel_r)
                0: a = 12'(4 * $urandom_range(0, 7));
                1: a = 12'('h080 + 4 * $urandom_range(0, 7));
                2: a = 12'('h100 + 4 * $urandom_range(0, 7));
                3: a = 12'('h180 + 4 * $urandom_range(0, 7));
                4: a = 12'('h300 + 4 * $urandom_range(0, 3));
                5: a = 12'('h510 + 4 * $urandom_range(0, 7));
                6: a = 12'('h590 + 4 * $urandom_range(0, 7));
                7: a = 12'('h610 + 4 * $urandom_range(0, 3));
                8: a = 12'($urandom_range(0, 4095));
                default: a = 12'h30C;
            endcase
            cyc("R3", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
                $urandom() | 32'($urandom_range(0, 1)),
                8'(($urandom_range(0, 3) == 0) ? $urandom() : 0),
                16'(($urandom_range(0, 3) == 0) ? $urandom() : 0));
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule